// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Flags

This block receives asynchronous serial frames and presents each one to a processor through a holding register. The serial line is brought into the clock domain through a two-stage synchronizer and sampled with a tick that runs at sixteen times the bit rate. A frame begins when the line falls to low. Mid-bit sampling then recovers the data bits, an optional parity bit and the stop bit. The word is assembled according to the selected length (seven or eight bits) and bit order. It is then moved into the holding register, and the full flag is raised.

The processor reads the word with a single-cycle read strobe, and that read drops the full flag. Parity, framing and overrun faults each set their own sticky flag. The word is trustworthy only while the full flag is 1 and all three fault flags are 0. The interrupt output is asserted whenever the full flag is set and interrupts are enabled.

The frame controller has five states. IDLE waits for a low line on a tick and moves to START. START confirms the start bit at mid-bit: a low level moves to DATA and a high level returns to IDLE as a glitch. DATA samples each data bit and leaves after the last one, going to PARITY when parity is on and to STOP otherwise. PARITY samples one bit and moves to STOP. STOP samples the stop bit, issues the completion pulse and returns to IDLE. Any state drops to IDLE when receive enable is 0.

Top module: `serial_rx_core`

## Requirements
- R1: In 8-bit mode (len8=1) with lsb_first order (msb_first=0) and no parity, a received frame appears on rx_data with bit 0 taken from the first bit after the start bit, and data_full becomes 1.
- R2: With msb_first=1, the first data bit received lands in the most significant data position of the word.
- R3: In 7-bit mode (len8=0), seven data bits are received, and rx_data[7] is 0 for either bit order.
- R4: rx_irq is 1 exactly when data_full is 1 and irq_en is 1.
- R5: A one-cycle rd_stb clears data_full to 0.
- R6: par_mode 2'b01 selects even parity and 2'b10 selects odd parity; 2'b00 and 2'b11 mean no parity bit. A parity bit that does not match the selected mode sets err_parity.
- R7: A stop bit sampled as 0 sets err_frame.
- R8: A frame that completes while data_full is 1 sets err_overrun and leaves rx_data at its earlier value.
- R9: err_parity, err_overrun and err_frame stay set until err_clr is pulsed or rx_en goes to 0, and either of these clears all three.
- R10: A low level on the line that has returned high at the mid-point of the start bit (8 ticks after the fall) is discarded, and no word is delivered.
- R11: While rx_en is 0, no frame is received and data_full does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| tick16 | input | 1 | Single-cycle pulse at 16 times the bit rate |
| rx_en | input | 1 | Receive enable |
| irq_en | input | 1 | Receive interrupt enable |
| len8 | input | 1 | 1: eight data bits, 0: seven data bits |
| msb_first | input | 1 | 1: most significant bit first, 0: least significant first |
| par_mode | input | 2 | 00/11 none, 01 even, 10 odd |
| rd_stb | input | 1 | Processor read of the holding register |
| err_clr | input | 1 | Clears the three fault flags |
| rx_data | output | 8 | Holding register |
| data_full | output | 1 | Holding register holds an unread word |
| err_parity | output | 1 | Parity fault flag |
| err_overrun | output | 1 | Overrun fault flag |
| err_frame | output | 1 | Framing fault flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The assertions check the following on every cycle: a read empties the register, an overrun sets its flag while the held word stays put, a clear or a disable empties the fault flags, the seventh-bit position stays zero in 7-bit mode, the controller returns to IDLE when disabled, and the completion pulse lasts one cycle. Only the bench scenarios can show that the bits of a real waveform land in the right word positions for each order and length. They also show that parity and stop faults are caught from line levels, that a short low pulse is rejected at mid-bit, and that the interrupt follows its enable.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP
    } srx_state_t;

    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;
endpackage

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              tick,
    input  logic              line,
    input  logic              len_full,
    input  logic              msb_first,
    input  logic [1:0]        par_mode,
    output logic              done,
    output logic [DATA_W-1:0] word,
    output logic              par_err,
    output logic              frm_err
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    srx_state_t        state, nstate;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sh;
    logic              pbit;
    logic              par_en;
    logic              at_mid, at_end;
    logic [IDX_W-1:0]  last_idx;

    assign par_en   = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
    assign at_mid   = tick && (cnt == MID);
    assign at_end   = tick && (cnt == LAST);
    assign last_idx = len_full ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);

    always_comb begin
        if (len_full)       word = sh;
        else if (msb_first) word = {1'b0, sh[DATA_W-2:0]};
        else                word = {1'b0, sh[DATA_W-1:1]};
    end

    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:   if (tick && !line) nstate = S_START;
            S_START:  if (at_mid) nstate = line ? S_IDLE : S_DATA;
            S_DATA:   if (at_end && idx == last_idx) nstate = par_en ? S_PARITY : S_STOP;
            S_PARITY: if (at_end) nstate = S_STOP;
            S_STOP:   if (at_end) nstate = S_IDLE;
            default:  nstate = S_IDLE;
        endcase
        if (!rx_en) nstate = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            idx     <= '0;
            sh      <= '0;
            pbit    <= 1'b0;
            done    <= 1'b0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state != nstate)  cnt <= '0;
            else if (tick)        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (state != S_DATA)  idx <= '0;
            if (state == S_DATA && at_end) begin
                idx <= idx + 1'b1;
                if (msb_first) sh <= {sh[DATA_W-2:0], line};
                else           sh <= {line, sh[DATA_W-1:1]};
            end
            if (state == S_PARITY && at_end) pbit <= line;
            if (state == S_STOP && at_end && rx_en) begin
                done    <= 1'b1;
                frm_err <= ~line;
                par_err <= par_en && ((^word ^ pbit) != (par_mode == PAR_ODD));
            end
        end
    end

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> state == S_IDLE); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1
endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              len_full,
    input  logic              done,
    input  logic [DATA_W-1:0] word,
    input  logic              pe_in,
    input  logic              fe_in,
    input  logic              rd_stb,
    input  logic              err_clr,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              pe,
    output logic              ore,
    output logic              fe
);
    logic overrun;
    assign overrun = done && full && !rd_stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            full <= 1'b0;
        end else if (done && !overrun) begin
            data <= word;
            full <= 1'b1;
        end else if (rd_stb) begin
            full <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pe  <= 1'b0;
            ore <= 1'b0;
            fe  <= 1'b0;
        end else if (!rx_en || err_clr) begin
            pe  <= 1'b0;
            ore <= 1'b0;
            fe  <= 1'b0;
        end else if (done) begin
            if (overrun) ore <= 1'b1;
            else begin
                pe <= pe | pe_in;
                fe <= fe | fe_in;
            end
        end
    end

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !done |=> !full); // R5
    AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        done && full && !rd_stb && rx_en && !err_clr |=> ore); // R8
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        full && !rd_stb |=> $stable(data)); // R8
    AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr || !rx_en |=> !pe && !ore && !fe); // R9
    AST_SEVEN_BIT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        done && !full && !len_full |=> !data[DATA_W-1]); // R3
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              tick16,
    input  logic              rx_en,
    input  logic              irq_en,
    input  logic              len8,
    input  logic              msb_first,
    input  logic [1:0]        par_mode,
    input  logic              rd_stb,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_full,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              err_frame,
    output logic              rx_irq
);
    logic [1:0]        sync_q;
    logic              done;
    logic [DATA_W-1:0] word;
    logic              pe_in, fe_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_line};
    end

    srx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(tick16),
        .line(sync_q[1]), .len_full(len8), .msb_first(msb_first),
        .par_mode(par_mode), .done(done), .word(word),
        .par_err(pe_in), .frm_err(fe_in)
    );

    srx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .len_full(len8),
        .done(done), .word(word), .pe_in(pe_in), .fe_in(fe_in),
        .rd_stb(rd_stb), .err_clr(err_clr), .data(rx_data),
        .full(data_full), .pe(err_parity), .ore(err_overrun), .fe(err_frame)
    );

    assign rx_irq = data_full & irq_en;
endmodule

// File: tb/test_serial_rx_core.sv
module test_serial_rx_core;
    localparam int BITCLK = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_line = 1'b1;
    logic tick16;
    logic rx_en = 1'b0, irq_en = 1'b0, len8 = 1'b1, msb_first = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic rd_stb = 1'b0, err_clr = 1'b0;
    logic [7:0] rx_data;
    logic data_full, err_parity, err_overrun, err_frame, rx_irq;
    logic [1:0] tdiv = 2'b00;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;
    always_ff @(posedge clk) tdiv <= tdiv + 1'b1;
    assign tick16 = (tdiv == 2'b11);

    serial_rx_core i_serial_rx_core (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
        .rx_en(rx_en), .irq_en(irq_en), .len8(len8), .msb_first(msb_first),
        .par_mode(par_mode), .rd_stb(rd_stb), .err_clr(err_clr),
        .rx_data(rx_data), .data_full(data_full), .err_parity(err_parity),
        .err_overrun(err_overrun), .err_frame(err_frame), .rx_irq(rx_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rx_line = b;
        repeat (BITCLK) @(negedge clk);
    endtask

    // pmode: 0 none, 1 even, 2 odd
    task automatic send(input logic [7:0] v, input int nb, input bit msb,
                        input int pmode, input bit flip, input logic stopb);
        logic p;
        p = 1'b0;
        @(negedge clk);
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            drive_bit(msb ? v[nb-1-i] : v[i]);
            p = p ^ (msb ? v[nb-1-i] : v[i]);
        end
        if (pmode != 0) drive_bit((pmode == 2 ? ~p : p) ^ flip);
        drive_bit(stopb);
        rx_line = 1'b1;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic pulse_rd;
        rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clr;
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset;
        check("reset full", data_full, 0);
        check("reset data", rx_data, 0);
        check("reset flags", {err_parity, err_overrun, err_frame}, 0);
        check("reset irq", rx_irq, 0);
    endtask

    task automatic t_lsb8;
        len8 = 1; msb_first = 0; par_mode = 2'b00;
        send(8'hA3, 8, 0, 0, 0, 1);
        check("R1 data", rx_data, 8'hA3);
        check("R1 full", data_full, 1);
        check("R1 flags", {err_parity, err_overrun, err_frame}, 0);
        pulse_rd;
    endtask

    task automatic t_msb8;
        msb_first = 1;
        send(8'h2C, 8, 1, 0, 0, 1);
        check("R2 msb order", rx_data, 8'h2C);
        pulse_rd;
        msb_first = 0;
    endtask

    task automatic t_seven;
        len8 = 0; msb_first = 0;
        send(8'h55, 7, 0, 0, 0, 1);
        check("R3 lsb 7bit", rx_data, 8'h55);
        pulse_rd;
        msb_first = 1;
        send(8'h7E, 7, 1, 0, 0, 1);
        check("R3 msb 7bit", rx_data, 8'h7E);
        pulse_rd;
        len8 = 1; msb_first = 0;
    endtask

    task automatic t_irq_read;
        irq_en = 0;
        send(8'h11, 8, 0, 0, 0, 1);
        check("R4 irq masked", rx_irq, 0);
        irq_en = 1; @(negedge clk);
        check("R4 irq on", rx_irq, 1);
        pulse_rd;
        check("R5 read clears full", data_full, 0);
        check("R4 irq off after read", rx_irq, 0);
        irq_en = 0;
    endtask

    task automatic t_parity;
        par_mode = 2'b01;
        send(8'h37, 8, 0, 1, 0, 1);
        check("R6 even good", err_parity, 0);
        check("R6 even data", rx_data, 8'h37);
        pulse_rd;
        send(8'h37, 8, 0, 1, 1, 1);
        check("R6 even bad", err_parity, 1);
        pulse_rd; pulse_clr;
        par_mode = 2'b10;
        send(8'h80, 8, 0, 2, 0, 1);
        check("R6 odd good", err_parity, 0);
        pulse_rd;
        send(8'h80, 8, 0, 2, 1, 1);
        check("R6 odd bad", err_parity, 1);
        pulse_rd; pulse_clr;
        check("R9 clr strobe", err_parity, 0);
        par_mode = 2'b00;
    endtask

    task automatic t_frame;
        send(8'h0F, 8, 0, 0, 0, 0);
        check("R7 framing", err_frame, 1);
        pulse_rd;
        send(8'h10, 8, 0, 0, 0, 1);
        check("R9 sticky frame", err_frame, 1);
        pulse_rd;
        rx_en = 0; @(negedge clk); @(negedge clk);
        check("R9 disable clears", {err_parity, err_overrun, err_frame}, 0);
        rx_en = 1; repeat (4) @(negedge clk);
    endtask

    task automatic t_overrun;
        send(8'hC4, 8, 0, 0, 0, 1);
        send(8'h3B, 8, 0, 0, 0, 1);
        check("R8 overrun flag", err_overrun, 1);
        check("R8 data kept", rx_data, 8'hC4);
        pulse_rd; pulse_clr;
        check("R9 overrun cleared", err_overrun, 0);
    endtask

    task automatic t_glitch;
        @(negedge clk);
        rx_line = 0; repeat (12) @(negedge clk);
        rx_line = 1; repeat (20 * BITCLK) @(negedge clk);
        check("R10 glitch ignored", data_full, 0);
    endtask

    task automatic t_disabled;
        rx_en = 0;
        send(8'h99, 8, 0, 0, 0, 1);
        check("R11 disabled no data", data_full, 0);
        rx_en = 1; repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        rx_en = 1; repeat (4) @(negedge clk);
        t_lsb8;
        t_msb8;
        t_seven;
        t_irq_read;
        t_parity;
        t_frame;
        t_overrun;
        t_glitch;
        t_disabled;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule